// File: doc/BRIEF.md
# Self-Correcting Six-State Toggle Counter

This block is a 3-bit synchronous counter whose state bits are held in toggle flip-flops. On every enabled clock it advances through a fixed six-step loop: 000, 001, 011, 111, 110, 100, then back to 000. Each step flips exactly one bit, so the output is a single-bit-change code. Consumers can use it as a compact phase generator or as a glitch-tolerant sequencer.

Two 3-bit codes, 010 and 101, are outside the loop. If their next states were left free, the counter could end up trapped in a stray loop between them. Both codes are therefore given an explicit successor of 000, so the counter rejoins the main loop one enabled clock after entering either code. The state loaded by the synchronous reset is a parameter. Its default is 000. Other values exist only so that verification can start the counter on an unused code.

The control part computes one toggle strobe per bit as the present bit XOR the wanted next bit. When the enable is low, every strobe is zero. The datapath holds the three toggle cells.

Top module: `tcycle_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes the reset code on that edge (000 by default), whatever `countEn` is.
- R2: When `rst` is low and `countEn` is low at a rising edge, `state` keeps its value.
- R3: With `rst` low and `countEn` high, each edge moves `state` one step along 000 → 001 → 011 → 111 → 110 → 100 → 000.
- R4: From the unused code 010, one enabled edge moves `state` to 000.
- R5: From the unused code 101, one enabled edge moves `state` to 000.
- R6: Every enabled step taken from a code in the main loop changes exactly one bit of `state`.
- R7: After any enabled or reset edge, `state` is never 010 or 101, so the unused codes can never form a closed loop.
- R8: When `countEn` is low, the toggle strobes sent from control to the datapath are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to the reset code |
| countEn | input | 1 | Advance the counter on this edge when high |
| state | output | 3 | Present counter code |

## Verification
Reset and count enable can both be high on the same edge. The bench raises them together partway through a counting run, with the counter away from 000. It expects the output to be 000 after that edge rather than the loop successor. It then checks that counting resumes from 001 on the next enabled edge. The unused codes are reached by building extra instances whose reset code is 010 or 101. Each is held with the enable low, then released to confirm that it jumps to 000 and follows the main loop from there.

// File: rtl/tcycle_pkg.sv
`timescale 1ns/1ps
package tcycle_pkg;

  localparam int StateWidth = 3;

  typedef logic [StateWidth-1:0] code_t;

  // Strobes sent from control to the datapath each cycle
  typedef struct packed {
    logic  clear;
    code_t toggle;
  } strobe_t;

  // Successor of every code; unused codes fall back to the loop start
  function automatic code_t nextCode(input code_t cur);
    code_t nxt;
    unique case (cur)
      3'b000:  nxt = 3'b001;
      3'b001:  nxt = 3'b011;
      3'b011:  nxt = 3'b111;
      3'b111:  nxt = 3'b110;
      3'b110:  nxt = 3'b100;
      3'b100:  nxt = 3'b000;
      default: nxt = 3'b000;  // 010 and 101 rejoin at 000
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tcycle_ctrl.sv
`timescale 1ns/1ps
module tcycle_ctrl
  import tcycle_pkg::*;
(
  input  logic    rst,
  input  logic    countEn,
  input  code_t   curState,
  output strobe_t strobe
);

  code_t wantState;

  always_comb begin
    wantState    = nextCode(curState);
    strobe.clear = rst;
    // T input of each cell: present bit XOR desired bit
    strobe.toggle = countEn ? (curState ^ wantState) : '0;
  end

endmodule

// File: rtl/tcycle_datapath.sv
`timescale 1ns/1ps
module tcycle_datapath
  import tcycle_pkg::*;
#(
  parameter code_t START_CODE = 3'b000
) (
  input  logic    clk,
  input  strobe_t strobe,
  output code_t   curState
);

  for (genvar b = 0; b < StateWidth; b++) begin : g_cell
    logic cellQ;
    always_ff @(posedge clk) begin
      if (strobe.clear)          cellQ <= START_CODE[b];
      else if (strobe.toggle[b]) cellQ <= ~cellQ;
    end
    assign curState[b] = cellQ;
  end

endmodule

// File: rtl/tcycle_counter.sv
`timescale 1ns/1ps
module tcycle_counter
  import tcycle_pkg::*;
#(
  parameter logic [2:0] START_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       countEn,
  output logic [2:0] state
);

  strobe_t ctrlStrobe;
  code_t   curState;

  tcycle_ctrl ctrl_i (
    .rst      (rst),
    .countEn  (countEn),
    .curState (curState),
    .strobe   (ctrlStrobe)
  );

  tcycle_datapath #(.START_CODE(START_CODE)) dp_i (
    .clk      (clk),
    .strobe   (ctrlStrobe),
    .curState (curState)
  );

  assign state = curState;

endmodule

// File: rtl/tcycle_counter_chk.sv
`timescale 1ns/1ps
module tcycle_counter_chk #(
  parameter logic [2:0] START_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       countEn,
  input logic [2:0] state,
  input logic [2:0] toggleStrobe
);

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  assert_reset_code_R1: assert property (@(posedge clk)
    rst |=> state == START_CODE);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    !countEn |=> $stable(state));

  assert_step_zero_R3: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state == 3'b000) |=> state == 3'b001);

  assert_step_seven_R3: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state == 3'b111) |=> state == 3'b110);

  assert_step_four_R3: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state == 3'b100) |=> state == 3'b000);

  assert_unused_two_R4: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state == 3'b010) |=> state == 3'b000);

  assert_unused_five_R5: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state == 3'b101) |=> state == 3'b000);

  assert_one_bit_R6: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    (countEn && state != 3'b010 && state != 3'b101)
      |=> $countones(state ^ $past(state)) == 1);

  assert_no_unused_R7: assert property (@(posedge clk) disable iff (rst || !seenEdge)
    countEn |=> (state != 3'b010 && state != 3'b101));

  assert_quiet_strobe_R8: assert property (@(posedge clk) disable iff (!seenEdge)
    !countEn |-> toggleStrobe == 3'b000);

endmodule

bind tcycle_counter tcycle_counter_chk #(.START_CODE(START_CODE)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .countEn      (countEn),
  .state        (state),
  .toggleStrobe (ctrlStrobe.toggle)
);

// File: tb/tcycle_counter_tb_top.sv
`timescale 1ns/1ps
module tcycle_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       countEn = 1'b0;
  logic [2:0] state;

  logic       rstX = 1'b1;
  logic       enX = 1'b0;
  logic [2:0] stateTwo, stateFive;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tcycle_counter dut_i (.clk(clk), .rst(rst), .countEn(countEn), .state(state));
  tcycle_counter #(.START_CODE(3'b010)) dut_two_i (
    .clk(clk), .rst(rstX), .countEn(enX), .state(stateTwo));
  tcycle_counter #(.START_CODE(3'b101)) dut_five_i (
    .clk(clk), .rst(rstX), .countEn(enX), .state(stateFive));

  typedef struct packed {
    logic       vRst;
    logic       vEn;
    logic [2:0] vExp;
  } vec_t;

  localparam int NumVec = 15;
  localparam vec_t Vecs [NumVec] = '{
    '{1'b1, 1'b0, 3'b000},  // R1 reset
    '{1'b0, 1'b1, 3'b001},  // R3
    '{1'b0, 1'b1, 3'b011},  // R3
    '{1'b0, 1'b0, 3'b011},  // R2 hold
    '{1'b0, 1'b1, 3'b111},  // R3
    '{1'b0, 1'b1, 3'b110},  // R3
    '{1'b0, 1'b0, 3'b110},  // R2 hold
    '{1'b0, 1'b1, 3'b100},  // R3
    '{1'b0, 1'b1, 3'b000},  // R3 wrap
    '{1'b0, 1'b1, 3'b001},  // R3
    '{1'b0, 1'b1, 3'b011},  // R3
    '{1'b1, 1'b1, 3'b000},  // R1 reset beats enable
    '{1'b0, 1'b1, 3'b001},  // R3 resume
    '{1'b1, 1'b0, 3'b000},  // R1 reset with enable low
    '{1'b0, 1'b0, 3'b000}   // R2 hold at zero
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: state=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic stepMain(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    countEn = e;
    @(posedge clk);
    #1;
  endtask

  task automatic stepAlt(input logic r, input logic e);
    @(negedge clk);
    rstX = r;
    enX = e;
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    // Vector walk on the default instance
    for (int i = 0; i < NumVec; i++) begin
      stepMain(Vecs[i].vRst, Vecs[i].vEn);
      check($sformatf("R1/R2/R3 vector %0d", i), state, Vecs[i].vExp);
    end

    // R6: single-bit change for a full lap
    begin
      logic [2:0] prev;
      stepMain(1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
        prev = state;
        stepMain(1'b0, 1'b1);
        testsRun++;
        if ($countones(prev ^ state) != 1) begin
          testsFailed++;
          $display("FAIL R6: step %b->%b changed %0d bits, expected 1",
                   prev, state, $countones(prev ^ state));
        end
      end
      check("R3 lap returns to 000", state, 3'b000);
    end

    // Unused-code instances
    stepAlt(1'b1, 1'b0);
    check("R1 reset code 010", stateTwo, 3'b010);
    check("R1 reset code 101", stateFive, 3'b101);
    stepAlt(1'b0, 1'b0);
    check("R2 hold on 010", stateTwo, 3'b010);
    check("R2 hold on 101", stateFive, 3'b101);
    stepAlt(1'b0, 1'b1);
    check("R4 010 -> 000", stateTwo, 3'b000);
    check("R5 101 -> 000", stateFive, 3'b000);
    stepAlt(1'b0, 1'b1);
    check("R7 after 010 follows loop", stateTwo, 3'b001);
    check("R7 after 101 follows loop", stateFive, 3'b001);
    stepAlt(1'b0, 1'b1);
    check("R7 loop continues", stateTwo, 3'b011);
    // R8: strobes quiet with enable low, seen as no state change
    stepAlt(1'b0, 1'b0);
    check("R8 no toggle with enable low", stateFive, 3'b011);

    finish();
  end

  initial begin
    #(200000 * 4);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

endmodule